// File: doc/BRIEF.md
# Prescaled 64-bit Compare Timer

This block is the machine-timer core for a single hart that has one compare channel. A programmable prescaler divides the fixed system clock down to a periodic one-cycle tick. Each tick adds a programmable step to a free-running 64-bit time value. Software sets the prescale divisor and the step together. This keeps the time base at a fixed real-time rate, for example one microsecond, whatever the clock frequency.

The time value is compared with a 64-bit compare value on every cycle. The block holds an interrupt status bit that hardware updates from that unsigned comparison. A level interrupt line is asserted when the status bit and the interrupt enable are both set. Configuration arrives through register-style write strobes with data. The block keeps the configuration registers itself, so their reset values are defined inside it. Software can overwrite either 32-bit half of the time value, and these writes win over a tick that lands in the same cycle.

Top module: `mtimer_core`

## Requirements
- R1: Reset leaves the time value at 0, interrupt status 0, interrupt line 0, prescale 0, active 0, interrupt enable 0, and both compare words at all ones.
- R2: The step register resets to 1, so enabling the timer with prescale 0 and no step write advances time by exactly 1 per clock.
- R3: On each tick the time value increases by the current step (zero-extended), and it does not change in a cycle without a tick or a counter write.
- R4: With prescale P, the tick period is P+1 clocks. When the active bit is written to 1 at clock edge n, the first increment of the time value lands at edge n+P+1.
- R5: The status bit is loaded at every edge with the unsigned comparison time >= compare, evaluated on the values held before that edge. Equality counts as expired, and a compare word with bit 63 set is treated as larger than any time value with bit 63 clear.
- R6: The interrupt line equals status AND interrupt enable. A status of 1 with the enable at 0 gives no interrupt.
- R7: A write to the low word (bits 31:0) or the high word (bits 63:32) of the time value replaces only that word. Such a write takes priority over a tick in the same cycle, and no increment happens in that cycle.
- R8: The time value wraps modulo 2^64: adding the step to all ones gives step-1.
- R9: While the active bit is 0 the time value holds and the prescaler count is held at 0, so after re-activation a full P+1 period elapses before the next increment.
- R10: If the prescale value is lowered below the current prescaler count, a tick occurs in the very next cycle and the count restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Strobe to load the active and interrupt-enable bits |
| ctrl_active_i | input | 1 | Active bit value written by ctrl_wr_i |
| ctrl_irq_en_i | input | 1 | Interrupt enable value written by ctrl_wr_i |
| pre_wr_i | input | 1 | Strobe to load the prescale register |
| pre_val_i | input | PRE_W | Prescale value (tick period minus one) |
| step_wr_i | input | 1 | Strobe to load the step register |
| step_val_i | input | STEP_W | Step added per tick |
| cmp_lo_wr_i | input | 1 | Strobe to load compare bits 31:0 from wdata_i |
| cmp_hi_wr_i | input | 1 | Strobe to load compare bits 63:32 from wdata_i |
| time_lo_wr_i | input | 1 | Strobe to load time bits 31:0 from wdata_i |
| time_hi_wr_i | input | 1 | Strobe to load time bits 63:32 from wdata_i |
| wdata_i | input | 32 | Shared write data for compare and time words |
| time_o | output | 64 | Current time value |
| irq_status_o | output | 1 | Interrupt status (hardware-written) |
| irq_o | output | 1 | Level interrupt line |

## Verification
The hardest case to reach is a prescale value lowered below a count the prescaler has already passed. The count cannot be seen from the ports, so the stimulus activates the timer with a known large divisor and counts a known number of clocks from the activation edge. It then writes a smaller divisor and expects the increment on the next edge, without waiting for a full period. The wrap at 2^64 and the unsigned top-bit comparison are reached by writing both time words directly rather than by waiting, and a per-cycle reference model in the scoreboard checks every cycle in between.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int unsigned TIME_W = 64;
  localparam int unsigned WORD_W = TIME_W / 2;

  // time plus increment, modulo 2^TIME_W
  function automatic logic [TIME_W-1:0] advance(input logic [TIME_W-1:0] t,
                                                input logic [TIME_W-1:0] inc);
    return t + inc;
  endfunction

  // unsigned expiry test
  function automatic logic reached(input logic [TIME_W-1:0] t,
                                   input logic [TIME_W-1:0] c);
    return t >= c;
  endfunction
endpackage

// File: rtl/mtimer_cfg.sv
module mtimer_cfg #(
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned STEP_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ctrl_wr_i,
  input  logic                          ctrl_active_i,
  input  logic                          ctrl_irq_en_i,
  input  logic                          pre_wr_i,
  input  logic [PRE_W-1:0]              pre_val_i,
  input  logic                          step_wr_i,
  input  logic [STEP_W-1:0]             step_val_i,
  input  logic                          cmp_lo_wr_i,
  input  logic                          cmp_hi_wr_i,
  input  logic [mtimer_pkg::WORD_W-1:0] wdata_i,
  output logic                          active_o,
  output logic                          irq_en_o,
  output logic [PRE_W-1:0]              pre_o,
  output logic [STEP_W-1:0]             step_o,
  output logic [mtimer_pkg::TIME_W-1:0] cmp_o
);
  localparam int unsigned WORD_W = mtimer_pkg::WORD_W;

  logic [1:0] cmp_wr;
  assign cmp_wr = {cmp_hi_wr_i, cmp_lo_wr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      irq_en_o <= 1'b0;
      pre_o    <= '0;
      step_o   <= STEP_W'(1);
    end else begin
      if (ctrl_wr_i) begin
        active_o <= ctrl_active_i;
        irq_en_o <= ctrl_irq_en_i;
      end
      if (pre_wr_i)  pre_o  <= pre_val_i;
      if (step_wr_i) step_o <= step_val_i;
    end
  end

  // one register per compare word, reset to all ones
  for (genvar g = 0; g < 2; g++) begin : g_cmp_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cmp_o[g*WORD_W +: WORD_W] <= '1;
      else if (cmp_wr[g]) cmp_o[g*WORD_W +: WORD_W] <= wdata_i;
    end
  end
endmodule

// File: rtl/mtimer_tick.sv
module mtimer_tick #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             tick_o,
  output logic [PRE_W-1:0] cnt_o
);
  logic [PRE_W-1:0] cnt_q;

  // >= so a lowered divisor fires at once
  assign tick_o = active_i && (cnt_q >= prescale_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!active_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/mtimer_count.sv
module mtimer_count (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic [mtimer_pkg::TIME_W-1:0] inc_i,
  input  logic                          lo_wr_i,
  input  logic                          hi_wr_i,
  input  logic [mtimer_pkg::WORD_W-1:0] wdata_i,
  output logic [mtimer_pkg::TIME_W-1:0] time_o
);
  localparam int unsigned TIME_W = mtimer_pkg::TIME_W;
  localparam int unsigned WORD_W = mtimer_pkg::WORD_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_o <= '0;
    end else if (lo_wr_i || hi_wr_i) begin
      if (lo_wr_i) time_o[WORD_W-1:0]      <= wdata_i;
      if (hi_wr_i) time_o[TIME_W-1:WORD_W] <= wdata_i;
    end else if (tick_i) begin
      time_o <= mtimer_pkg::advance(time_o, inc_i);
    end
  end
endmodule

// File: rtl/mtimer_expiry.sv
module mtimer_expiry (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [mtimer_pkg::TIME_W-1:0] time_i,
  input  logic [mtimer_pkg::TIME_W-1:0] cmp_i,
  input  logic                          irq_en_i,
  output logic                          expire_o,
  output logic                          status_o,
  output logic                          irq_o
);
  assign expire_o = mtimer_pkg::reached(time_i, cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= 1'b0;
    else         status_o <= expire_o;
  end

  assign irq_o = status_o && irq_en_i;
endmodule

// File: rtl/mtimer_core.sv
module mtimer_core #(
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned STEP_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ctrl_wr_i,
  input  logic                          ctrl_active_i,
  input  logic                          ctrl_irq_en_i,
  input  logic                          pre_wr_i,
  input  logic [PRE_W-1:0]              pre_val_i,
  input  logic                          step_wr_i,
  input  logic [STEP_W-1:0]             step_val_i,
  input  logic                          cmp_lo_wr_i,
  input  logic                          cmp_hi_wr_i,
  input  logic                          time_lo_wr_i,
  input  logic                          time_hi_wr_i,
  input  logic [mtimer_pkg::WORD_W-1:0] wdata_i,
  output logic [mtimer_pkg::TIME_W-1:0] time_o,
  output logic                          irq_status_o,
  output logic                          irq_o
);
  localparam int unsigned TIME_W = mtimer_pkg::TIME_W;

  // named internal events, used by the checker
  logic              active_w, irq_en_w, tick_w, expire_w, time_wr_w;
  logic [PRE_W-1:0]  pre_w, cnt_w;
  logic [STEP_W-1:0] step_w;
  logic [TIME_W-1:0] cmp_w, inc_w;

  assign time_wr_w = time_lo_wr_i || time_hi_wr_i;
  assign inc_w     = TIME_W'(step_w);

  mtimer_cfg #(.PRE_W(PRE_W), .STEP_W(STEP_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_active_i(ctrl_active_i), .ctrl_irq_en_i(ctrl_irq_en_i),
    .pre_wr_i(pre_wr_i), .pre_val_i(pre_val_i),
    .step_wr_i(step_wr_i), .step_val_i(step_val_i),
    .cmp_lo_wr_i(cmp_lo_wr_i), .cmp_hi_wr_i(cmp_hi_wr_i), .wdata_i(wdata_i),
    .active_o(active_w), .irq_en_o(irq_en_w), .pre_o(pre_w), .step_o(step_w), .cmp_o(cmp_w)
  );

  mtimer_tick #(.PRE_W(PRE_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_w), .prescale_i(pre_w),
    .tick_o(tick_w), .cnt_o(cnt_w)
  );

  mtimer_count u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .inc_i(inc_w),
    .lo_wr_i(time_lo_wr_i), .hi_wr_i(time_hi_wr_i), .wdata_i(wdata_i), .time_o(time_o)
  );

  mtimer_expiry u_exp (
    .clk_i(clk_i), .rst_ni(rst_ni), .time_i(time_o), .cmp_i(cmp_w), .irq_en_i(irq_en_w),
    .expire_o(expire_w), .status_o(irq_status_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/mtimer_core_chk.sv
module mtimer_core_chk #(
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned STEP_W = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          active_v,
  input logic                          tick_v,
  input logic                          wr_v,
  input logic                          expire_v,
  input logic [PRE_W-1:0]              cnt_v,
  input logic [STEP_W-1:0]             step_v,
  input logic [mtimer_pkg::TIME_W-1:0] time_v,
  input logic [mtimer_pkg::TIME_W-1:0] cmp_v,
  input logic                          status_v,
  input logic                          irq_v
);
  localparam int unsigned TIME_W = mtimer_pkg::TIME_W;

  a_r3_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_v && !wr_v) |=> $stable(time_v));

  a_r3_step_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_v && !wr_v) |=> (time_v == $past(time_v) + TIME_W'($past(step_v))));

  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_v |=> (cnt_v == '0));

  a_r4_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_v && !tick_v) |=> (cnt_v == $past(cnt_v) + PRE_W'(1)));

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_v |=> (cnt_v == '0));

  a_r9_idle_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_v |-> !tick_v);

  a_r5_status_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_v == ($past(time_v) >= $past(cmp_v))));

  a_r5_expire_eq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_v == cmp_v) |-> expire_v);

  a_r6_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_v |-> status_v);
endmodule

bind mtimer_core mtimer_core_chk #(.PRE_W(PRE_W), .STEP_W(STEP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .active_v(active_w), .tick_v(tick_w), .wr_v(time_wr_w),
  .expire_v(expire_w), .cnt_v(cnt_w), .step_v(step_w), .time_v(time_o), .cmp_v(cmp_w),
  .status_v(irq_status_o), .irq_v(irq_o)
);

// File: tb/mtimer_core_bench.sv
module mtimer_core_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 0, ctrl_act = 0, ctrl_en = 0;
  logic pre_wr = 0, step_wr = 0;
  logic [11:0] pre_val = '0;
  logic [7:0]  step_val = '0;
  logic cmp_lo_wr = 0, cmp_hi_wr = 0, t_lo_wr = 0, t_hi_wr = 0;
  logic [31:0] wdata = '0;
  logic [63:0] time_o;
  logic status_o, irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtimer_core u_mtimer_core (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_wr_i(ctrl_wr), .ctrl_active_i(ctrl_act), .ctrl_irq_en_i(ctrl_en),
    .pre_wr_i(pre_wr), .pre_val_i(pre_val), .step_wr_i(step_wr), .step_val_i(step_val),
    .cmp_lo_wr_i(cmp_lo_wr), .cmp_hi_wr_i(cmp_hi_wr),
    .time_lo_wr_i(t_lo_wr), .time_hi_wr_i(t_hi_wr), .wdata_i(wdata),
    .time_o(time_o), .irq_status_o(status_o), .irq_o(irq_o)
  );

  // ---------------- scoreboard: reference model pushes, monitor pops
  typedef struct packed {
    logic [63:0] t;
    logic        s;
    logic        i;
  } exp_t;
  exp_t exp_q[$];

  logic [11:0] m_cnt, m_pre;
  logic [7:0]  m_step;
  logic        m_act, m_en, m_stat;
  logic [63:0] m_time, m_cmp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_step = 8'd1; m_act = 0; m_en = 0; m_stat = 0;
      m_time = 0; m_cmp = '1;
    end else begin
      bit tk;
      logic [63:0] nt;
      tk = m_act && (m_cnt >= m_pre);
      m_stat = (m_time >= m_cmp);
      nt = m_time;
      if (t_lo_wr || t_hi_wr) begin
        if (t_lo_wr) nt[31:0]  = wdata;
        if (t_hi_wr) nt[63:32] = wdata;
      end else if (tk) begin
        nt = m_time + {56'd0, m_step};
      end
      m_time = nt;
      m_cnt  = (!m_act || tk) ? 12'd0 : m_cnt + 12'd1;
      if (ctrl_wr) begin m_act = ctrl_act; m_en = ctrl_en; end
      if (pre_wr)  m_pre  = pre_val;
      if (step_wr) m_step = step_val;
      if (cmp_lo_wr) m_cmp[31:0]  = wdata;
      if (cmp_hi_wr) m_cmp[63:32] = wdata;
    end
    exp_q.push_back('{t: m_time, s: m_stat, i: m_stat && m_en});
  end

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (time_o !== e.t) begin
        n_fail++;
        $display("FAIL R3 scoreboard time: actual %h expected %h", time_o, e.t);
      end
      n_checks++;
      if (status_o !== e.s) begin
        n_fail++;
        $display("FAIL R5 scoreboard status: actual %b expected %b", status_o, e.s);
      end
      n_checks++;
      if (irq_o !== e.i) begin
        n_fail++;
        $display("FAIL R6 scoreboard irq: actual %b expected %b", irq_o, e.i);
      end
    end
  end

  // ---------------- directed checks
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ctrl(input logic a, input logic e);
    ctrl_wr = 1; ctrl_act = a; ctrl_en = e; @(negedge clk); ctrl_wr = 0;
  endtask
  task automatic do_pre(input logic [11:0] v);
    pre_wr = 1; pre_val = v; @(negedge clk); pre_wr = 0;
  endtask
  task automatic do_step(input logic [7:0] v);
    step_wr = 1; step_val = v; @(negedge clk); step_wr = 0;
  endtask
  task automatic do_time(input logic lo, input logic hi, input logic [31:0] v);
    t_lo_wr = lo; t_hi_wr = hi; wdata = v; @(negedge clk); t_lo_wr = 0; t_hi_wr = 0;
  endtask
  task automatic do_cmp(input logic lo, input logic hi, input logic [31:0] v);
    cmp_lo_wr = lo; cmp_hi_wr = hi; wdata = v; @(negedge clk); cmp_lo_wr = 0; cmp_hi_wr = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] t0;
    logic [31:0] h;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 time", time_o, 64'd0);
    check("R1 status", {63'd0, status_o}, 64'd0);
    check("R1 irq", {63'd0, irq_o}, 64'd0);
    rst_n = 1;
    wait_n(2);
    check("R1 no expiry with reset compare", {63'd0, status_o}, 64'd0);

    // R2 default step of 1, prescale 0
    do_ctrl(1, 1);
    check("R2 before first tick", time_o, 64'd0);
    wait_n(2);
    check("R2 default step", time_o, 64'd2);
    check("R6 compare all ones keeps irq low", {63'd0, irq_o}, 64'd0);

    // R9 hold while inactive
    do_ctrl(0, 1);
    t0 = time_o;
    wait_n(5);
    check("R9 hold while inactive", time_o, t0);

    // R4 period P+1 with step 4 (R3)
    do_pre(12'd3);
    do_step(8'd4);
    t0 = time_o;
    do_ctrl(1, 1);
    wait_n(3);
    check("R4 no increment before P+1 edges", time_o, t0);
    wait_n(1);
    check("R3 increment by step at P+1", time_o, t0 + 64'd4);
    wait_n(3);
    check("R4 held between ticks", time_o, t0 + 64'd4);
    wait_n(1);
    check("R4 second period", time_o, t0 + 64'd8);

    // R10 lowering prescale below current count
    do_ctrl(0, 1);
    do_pre(12'd10);
    do_ctrl(1, 1);
    wait_n(6);
    t0 = time_o;
    do_pre(12'd2);
    check("R10 no tick at the write edge", time_o, t0);
    wait_n(1);
    check("R10 immediate tick after lowering", time_o, t0 + 64'd4);
    wait_n(2);
    check("R10 count restarted from zero", time_o, t0 + 64'd4);
    wait_n(1);
    check("R10 new period 3", time_o, t0 + 64'd8);

    // R7 write priority with a tick every cycle
    do_pre(12'd0);
    wait_n(2);
    h = time_o[63:32];
    do_time(1, 0, 32'h0000_0100);
    check("R7 low write wins over tick", time_o, {h, 32'h0000_0100});
    wait_n(1);
    check("R7 increment resumes", time_o, {h, 32'h0000_0104});
    do_time(0, 1, 32'h0000_00AB);
    check("R7 high write keeps low word", time_o[63:32], 64'h0000_00AB);

    // R8 wrap modulo 2^64
    do_time(1, 1, 32'hFFFF_FFFF);
    check("R8 all ones written", time_o, 64'hFFFF_FFFF_FFFF_FFFF);
    wait_n(1);
    check("R8 wrap", time_o, 64'd3);

    // R5 equality, ordering and unsigned compare, stopped timer
    do_ctrl(0, 1);
    do_time(1, 1, 32'd0);
    do_time(1, 0, 32'd5);
    do_cmp(1, 1, 32'd0);
    do_cmp(1, 0, 32'd5);
    wait_n(2);
    check("R5 equal counts as expired", {63'd0, status_o}, 64'd1);
    check("R6 irq with enable", {63'd0, irq_o}, 64'd1);
    do_ctrl(0, 0);
    wait_n(1);
    check("R6 status without enable", {62'd0, status_o, irq_o}, 64'd2);
    do_cmp(1, 0, 32'd6);
    wait_n(2);
    check("R5 time below compare", {63'd0, status_o}, 64'd0);
    do_time(0, 1, 32'h7FFF_FFFF);
    do_cmp(0, 1, 32'h8000_0000);
    wait_n(2);
    check("R5 unsigned top bit", {63'd0, status_o}, 64'd0);
    do_time(0, 1, 32'h8000_0001);
    wait_n(2);
    check("R5 passed compare", {63'd0, status_o}, 64'd1);

    wait_n(3);
    finish_run();
  end
endmodule